// File: doc/BRIEF.md
# Hot-Swap Channel Fault Sequencer

This block is the digital control core of one channel of a hot-swap power switch. Analog comparators for bias, enable, overcurrent and output level deliver plain flags to it. The block decides when the soft-start ramp may run, when the external pass transistor's gate may be driven, and when a fast gate discharge must be fired. It also reports a fault and a power-good status, both active low.

A programmable cycle counter replaces a timing capacitor. While the current-regulation flag stays set, the counter measures the allowed regulation time. When that time runs out, the channel shuts down. What happens next depends on the mode select:

- **Latch mode:** the channel stays off until enable is released and applied again.
- **Retry mode:** the channel waits a whole number of timeout periods, then starts a new soft-start by itself.

A way-overcurrent event fires a single-cycle gate discharge strobe. If the overload persists, the channel then falls into timed regulation.

Every flag input passes through a two-stage synchronizer before it is used. As a result, a change on any input reaches the state two clock edges later.

Top module: `hs_chan_seq`

## Requirements
- R1: While reset is held, or while the bias flag is low, all of the following hold: gate drive is off, soft-start is held discharged, the fault output is high and power-good is high. They stay that way for as long as bias is low.
- R2: With bias good, driving the active-low enable to 0 turns on both the gate drive and the soft-start run output. This happens on the third rising clock edge after the input change: two synchronizer edges plus one state edge.
- R3: A current-regulation episode that ends before the timeout expires causes no fault, and the gate stays on. The timeout counter is cleared, so a later episode again needs the full timeout.
- R4: Once the channel has spent TMO_CYCLES cycles in regulation, it shuts down in the following cycle. At that point the gate drive and soft-start go off and the fault output goes low. Measured from the flag input, shutdown falls on edge TMO_CYCLES+3.
- R5: In latch mode (retry select = 1), the channel stays off with the fault low, even after the overcurrent clears. Only a release of enable followed by a new assertion restarts it.
- R6: In retry mode (retry select = 0), the fault output stays low for exactly RETRY_PERIODS×TMO_CYCLES cycles. The fault then clears, and gate drive and soft-start restart in that same cycle.
- R7: If the overcurrent is still present after a retry, regulation starts again. The channel shuts down again TMO_CYCLES+1 edges after the restart.
- R8: A rising way-overcurrent flag on an enabled channel gives a gate-kill strobe exactly one cycle wide, on the third edge. The gate-enable output stays high through the strobe. If the overload persists, it is timed like regulation. No strobe fires while the channel is off.
- R9: Power-good (active low) follows the output-level flag with two edges of latency, and is forced high while bias is low.
- R10: Releasing enable at any time turns off gate drive and soft-start within three edges. This includes during regulation and during a retry wait, and in a retry wait it also clears the fault output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bias_ok_i | input | 1 | Bias above power-on threshold |
| en_n_i | input | 1 | Channel enable, active low |
| retry_n_i | input | 1 | 0 = auto-retry mode, 1 = latch-off mode |
| cr_i | input | 1 | Current-regulation threshold exceeded |
| woc_i | input | 1 | Way-overcurrent comparator tripped |
| uv_ok_i | input | 1 | Output above undervoltage level |
| ss_run_o | output | 1 | 1 = soft-start ramp runs, 0 = discharge |
| gate_en_o | output | 1 | Gate drive enable |
| gate_kill_o | output | 1 | One-cycle fast gate pulldown strobe |
| flt_n_o | output | 1 | Fault, active low |
| pg_n_o | output | 1 | Power good, active low |

## Verification
The assertions check four properties on every cycle:

- The gate is never driven while the fault output is low.
- The kill strobe never lasts two cycles.
- A falling fault always coincides with a gate that was on and is now off.
- A sustained low bias or released enable always forces the outputs off.

The directed scenarios cover what only sequences can show. This includes the exact timeout and retry-wait lengths, and that the timer was cleared after a short regulation episode. It also includes the latch versus retry outcome, repeated retry under a persistent short, and the power-good latency.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
   typedef enum logic [2:0] {
      ST_POR   = 3'd0,
      ST_IDLE  = 3'd1,
      ST_ON    = 3'd2,
      ST_CR    = 3'd3,
      ST_LATCH = 3'd4,
      ST_WAIT  = 3'd5
   } chan_st_t;

   localparam int unsigned SYNC_W = 6;
   localparam int unsigned IX_BIAS  = 5;
   localparam int unsigned IX_EN_N  = 4;
   localparam int unsigned IX_RTR_N = 3;
   localparam int unsigned IX_CR    = 2;
   localparam int unsigned IX_WOC   = 1;
   localparam int unsigned IX_UV    = 0;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hs_fault_timer.sv
module hs_fault_timer #(
   parameter int unsigned TMO_CYCLES    = 1000,
   parameter int unsigned RETRY_PERIODS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_tmo_i,
   input  logic run_wait_i,
   output logic tmo_hit_o,
   output logic retry_done_o
);
   localparam int unsigned TW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
   localparam int unsigned RW = $clog2(RETRY_PERIODS + 1);
   localparam logic [TW-1:0] T_LAST = TW'(TMO_CYCLES - 1);
   localparam logic [RW-1:0] R_LAST = RW'(RETRY_PERIODS - 1);

   generate
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("hs_fault_timer: TMO_CYCLES must be at least 2");
      end
      if (RETRY_PERIODS < 1) begin : g_bad_retry
         $error("hs_fault_timer: RETRY_PERIODS must be at least 1");
      end
   endgenerate

   logic [TW-1:0] tcnt;
   logic [RW-1:0] rcnt;
   logic          running;
   logic          wrap;

   assign running = run_tmo_i | run_wait_i;
   assign wrap    = running && (tcnt == T_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt <= '0;
         rcnt <= '0;
      end else begin
         if (!running)  tcnt <= '0;
         else if (wrap) tcnt <= '0;
         else           tcnt <= tcnt + 1'b1;

         if (!run_wait_i) rcnt <= '0;
         else if (wrap)   rcnt <= rcnt + 1'b1;
      end
   end

   assign tmo_hit_o    = wrap;
   assign retry_done_o = run_wait_i && wrap && (rcnt == R_LAST);
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
   import hs_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bias_s,
   input  logic     en_n_s,
   input  logic     retry_n_s,
   input  logic     cr_s,
   input  logic     woc_s,
   input  logic     tmo_hit,
   input  logic     retry_done,
   output chan_st_t state_o,
   output logic     kill_o
);
   chan_st_t st, st_nx;
   logic     woc_q, kill_q;
   logic     overload, gate_on;

   assign overload = cr_s | woc_s;
   assign gate_on  = (st == ST_ON) || (st == ST_CR);

   always_comb begin
      st_nx = st;
      if (!bias_s) begin
         st_nx = ST_POR;
      end else begin
         case (st)
            ST_POR:   st_nx = ST_IDLE;
            ST_IDLE:  if (!en_n_s) st_nx = ST_ON;
            ST_ON: begin
               if (en_n_s)        st_nx = ST_IDLE;
               else if (overload) st_nx = ST_CR;
            end
            ST_CR: begin
               if (en_n_s)         st_nx = ST_IDLE;
               else if (!overload) st_nx = ST_ON;
               else if (tmo_hit)   st_nx = retry_n_s ? ST_LATCH : ST_WAIT;
            end
            ST_LATCH: if (en_n_s) st_nx = ST_IDLE;
            ST_WAIT: begin
               if (en_n_s)          st_nx = ST_IDLE;
               else if (retry_done) st_nx = ST_ON;
            end
            default:  st_nx = ST_POR;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_POR;
         woc_q  <= 1'b0;
         kill_q <= 1'b0;
      end else begin
         st     <= st_nx;
         woc_q  <= woc_s;
         kill_q <= woc_s && !woc_q && gate_on;
      end
   end

   assign state_o = st;
   assign kill_o  = kill_q;
endmodule

// File: rtl/hs_chan_seq.sv
module hs_chan_seq
   import hs_seq_pkg::*;
#(
   parameter int unsigned TMO_CYCLES    = 1000,
   parameter int unsigned RETRY_PERIODS = 64,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bias_ok_i,
   input  logic en_n_i,
   input  logic retry_n_i,
   input  logic cr_i,
   input  logic woc_i,
   input  logic uv_ok_i,
   output logic ss_run_o,
   output logic gate_en_o,
   output logic gate_kill_o,
   output logic flt_n_o,
   output logic pg_n_o
);
   logic [SYNC_W-1:0] raw, syn;
   chan_st_t          st;
   logic              tmo_hit, retry_done;

   assign raw[IX_BIAS]  = bias_ok_i;
   assign raw[IX_EN_N]  = en_n_i;
   assign raw[IX_RTR_N] = retry_n_i;
   assign raw[IX_CR]    = cr_i;
   assign raw[IX_WOC]   = woc_i;
   assign raw[IX_UV]    = uv_ok_i;

   hs_sync #(
      .W       (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_W'(6'b011000))
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   hs_fault_timer #(
      .TMO_CYCLES    (TMO_CYCLES),
      .RETRY_PERIODS (RETRY_PERIODS)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_tmo_i    (st == ST_CR),
      .run_wait_i   (st == ST_WAIT),
      .tmo_hit_o    (tmo_hit),
      .retry_done_o (retry_done)
   );

   hs_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bias_s     (syn[IX_BIAS]),
      .en_n_s     (syn[IX_EN_N]),
      .retry_n_s  (syn[IX_RTR_N]),
      .cr_s       (syn[IX_CR]),
      .woc_s      (syn[IX_WOC]),
      .tmo_hit    (tmo_hit),
      .retry_done (retry_done),
      .state_o    (st),
      .kill_o     (gate_kill_o)
   );

   assign gate_en_o = (st == ST_ON) || (st == ST_CR);
   assign ss_run_o  = gate_en_o;
   assign flt_n_o   = !((st == ST_LATCH) || (st == ST_WAIT));
   assign pg_n_o    = !(syn[IX_UV] && syn[IX_BIAS] && (st != ST_POR));
endmodule

// File: rtl/hs_chan_seq_chk.sv
module hs_chan_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bias_ok_i,
   input logic en_n_i,
   input logic ss_run_o,
   input logic gate_en_o,
   input logic gate_kill_o,
   input logic flt_n_o,
   input logic pg_n_o
);
   assert_no_gate_in_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_en_o && !flt_n_o));

   assert_fault_on_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_n_o) |-> ($past(gate_en_o) && !gate_en_o));

   assert_kill_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      gate_kill_o |=> !gate_kill_o);

   assert_enable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n_i && $past(en_n_i) && $past(en_n_i, 2) && $past(en_n_i, 3))
      |-> (!gate_en_o && !ss_run_o));

   assert_bias_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!bias_ok_i && !$past(bias_ok_i) && !$past(bias_ok_i, 2) && !$past(bias_ok_i, 3))
      |-> (!gate_en_o && flt_n_o && pg_n_o));
endmodule

bind hs_chan_seq hs_chan_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bias_ok_i   (bias_ok_i),
   .en_n_i      (en_n_i),
   .ss_run_o    (ss_run_o),
   .gate_en_o   (gate_en_o),
   .gate_kill_o (gate_kill_o),
   .flt_n_o     (flt_n_o),
   .pg_n_o      (pg_n_o)
);

// File: tb/tb_hs_chan_seq.sv
`timescale 1ns/1ps
module tb_hs_chan_seq;
   localparam int TMO = 8;
   localparam int RPER = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bias_ok_i = 1'b0, en_n_i = 1'b1, retry_n_i = 1'b1;
   logic cr_i = 1'b0, woc_i = 1'b0, uv_ok_i = 1'b0;
   logic ss_run_o, gate_en_o, gate_kill_o, flt_n_o, pg_n_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   hs_chan_seq #(.TMO_CYCLES(TMO), .RETRY_PERIODS(RPER)) dut (
      .clk(clk), .rst_n(rst_n), .bias_ok_i(bias_ok_i), .en_n_i(en_n_i),
      .retry_n_i(retry_n_i), .cr_i(cr_i), .woc_i(woc_i), .uv_ok_i(uv_ok_i),
      .ss_run_o(ss_run_o), .gate_en_o(gate_en_o), .gate_kill_o(gate_kill_o),
      .flt_n_o(flt_n_o), .pg_n_o(pg_n_o)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_flt(input logic val, output int cnt);
      cnt = 0;
      while (flt_n_o !== val && cnt < 5000) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic t_reset();
      chk("R1 reset gate", gate_en_o, 0);
      chk("R1 reset flt", flt_n_o, 1);
      chk("R1 reset pg", pg_n_o, 1);
      rst_n = 1'b1; en_n_i = 1'b0; uv_ok_i = 1'b1;
      step(10);
      chk("R1 bias low gate", gate_en_o, 0);
      chk("R1 bias low ss", ss_run_o, 0);
      chk("R9 pg forced high with bias low", pg_n_o, 1);
      en_n_i = 1'b1; uv_ok_i = 1'b0;
      bias_ok_i = 1'b1;
      step(4);
   endtask

   task automatic t_start();
      en_n_i = 1'b0;
      step(2);
      chk("R2 gate not before edge 3", gate_en_o, 0);
      step(1);
      chk("R2 gate on", gate_en_o, 1);
      chk("R2 ss run", ss_run_o, 1);
      uv_ok_i = 1'b1;
      step(1);
      chk("R9 pg latency edge1", pg_n_o, 1);
      step(1);
      chk("R9 pg asserted", pg_n_o, 0);
      uv_ok_i = 1'b0;
      step(2);
      chk("R9 pg released", pg_n_o, 1);
   endtask

   task automatic t_short_cr();
      int c;
      cr_i = 1'b1;
      step(TMO - 1);
      cr_i = 1'b0;
      step(10);
      chk("R3 no fault after short episode", flt_n_o, 1);
      chk("R3 gate still on", gate_en_o, 1);
      retry_n_i = 1'b1;
      cr_i = 1'b1;
      wait_flt(1'b0, c);
      chk("R3 R4 full timeout latency", c, TMO + 3);
      chk("R4 gate off at fault", gate_en_o, 0);
      chk("R4 ss discharged at fault", ss_run_o, 0);
   endtask

   task automatic t_latch();
      cr_i = 1'b0;
      step(20);
      chk("R5 latched fault held", flt_n_o, 0);
      chk("R5 latched gate off", gate_en_o, 0);
      en_n_i = 1'b1;
      step(3);
      chk("R5 fault cleared on release", flt_n_o, 1);
      chk("R5 gate off while released", gate_en_o, 0);
      en_n_i = 1'b0;
      step(3);
      chk("R5 restart on re-enable", gate_en_o, 1);
   endtask

   task automatic t_retry();
      int c;
      retry_n_i = 1'b0;
      step(3);
      cr_i = 1'b1;
      wait_flt(1'b0, c);
      chk("R4 retry-mode timeout latency", c, TMO + 3);
      wait_flt(1'b1, c);
      chk("R6 wait length", c, RPER * TMO);
      chk("R6 gate on at retry", gate_en_o, 1);
      chk("R6 ss on at retry", ss_run_o, 1);
      wait_flt(1'b0, c);
      chk("R7 repeated shutdown", c, TMO + 1);
      step(5);
      en_n_i = 1'b1;
      step(3);
      chk("R10 release clears wait fault", flt_n_o, 1);
      chk("R10 release gate off", gate_en_o, 0);
      cr_i = 1'b0;
      en_n_i = 1'b0;
      step(3);
      chk("R10 restart after release", gate_en_o, 1);
      cr_i = 1'b1;
      step(5);
      en_n_i = 1'b1;
      step(3);
      chk("R10 release during regulation", ss_run_o, 0);
      cr_i = 1'b0;
   endtask

   task automatic t_woc();
      int c;
      retry_n_i = 1'b1;
      en_n_i = 1'b0;
      step(4);
      woc_i = 1'b1;
      step(2);
      chk("R8 no strobe before edge 3", gate_kill_o, 0);
      step(1);
      chk("R8 strobe", gate_kill_o, 1);
      chk("R8 gate enable kept during strobe", gate_en_o, 1);
      step(1);
      chk("R8 strobe one cycle", gate_kill_o, 0);
      wait_flt(1'b0, c);
      chk("R8 persistent overload timed", c + 4, TMO + 3);
      woc_i = 1'b0;
      en_n_i = 1'b1;
      step(4);
      woc_i = 1'b1;
      step(3);
      chk("R8 no strobe while off", gate_kill_o, 0);
      step(1);
      chk("R8 no strobe while off later", gate_kill_o, 0);
      woc_i = 1'b0;
   endtask

   initial begin
      step(3);
      t_reset();
      t_start();
      t_short_cr();
      t_latch();
      t_retry();
      t_woc();
      step(5);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule